// File: doc/BRIEF.md
# Row-Buffer DRAM Access Controller

This block lets user logic treat an embedded SDRAM-style core as if it were a plain synchronous SRAM. The user side offers a request strobe, a write select, a word address and 128-bit write data. Read data comes back on a fixed pipeline with a valid strobe. Requests may be issued every cycle. Each bank keeps one open row, and these open rows act as a direct-mapped cache. The bank field of the address selects the slot, and the row field is the tag.

Whenever a request cannot be served at once, the controller raises `stall`. There are four causes: a row miss, a write that follows a read, a host refresh halt, and the clock realignment after a halt. While `stall` is high the user must hold its request steady. For each hazard the controller counts a fixed penalty. It issues the precharge, activate, read, write and refresh commands to the core with fixed spacing.

Top module: `rowbuf_sram_ctrl`

## Requirements
- R1: After reset, with `req` and `halt` low, `stall` and `rdValid` are low and `dramCmd` is NOP (0).
- R2: The address splits, from the top down, into {row tag, bank, column}. The column field is COL_W bits and the bank field is BANK_W bits. A request whose bank holds an open row with an equal tag is a hit. A hit not preceded by a read (when it is a write) is accepted in the same cycle, with `stall` low.
- R3: A read accepted at clock edge A raises `rdValid` with that word's data after edge A+HIT_LAT (6). Reads accepted on consecutive cycles return on consecutive cycles, in order.
- R4: A miss holds `stall` high for exactly MISS_PEN (10) cycles, starting in the cycle the request is presented. During that time the controller issues PRE to the bank if it held an open row, then exactly one ACT of the new row. The request is accepted in the following cycle.
- R5: A write that hits, when the most recent accepted request was a read, holds `stall` high for exactly WAR_PEN (4) cycles. A write that misses pays only the miss penalty.
- R6: While `halt` is high, `stall` is high and no request is accepted. Each halt produces exactly one REF command and closes every open row, so the next access to any bank is a miss. A halt also clears the read history, so the first write after it is not charged the write-after-read penalty.
- R7: In the cycle after `halt` falls, `stall` is high for one realignment cycle, even with no request present.
- R8: A read returns the value of the most recent accepted write to that address.
- R9: `dramCmd` uses the encoding NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5. RD and WR go only to a bank whose open row equals `dramRow`. ACT goes only to a closed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held while stalled |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | TAG_W+BANK_W+COL_W | Word address {tag, bank, column} |
| wdata | input | DATA_W | Write data |
| halt | input | 1 | Host refresh halt |
| stall | output | 1 | Request not accepted this cycle |
| rdValid | output | 1 | Read data strobe |
| rdData | output | DATA_W | Read data |
| dramCmd | output | 3 | Core command code |
| dramBank | output | BANK_W | Core bank select |
| dramRow | output | TAG_W | Core row for ACT, RD, WR |
| dramCol | output | COL_W | Core column |
| dramWdata | output | DATA_W | Core write data |
| dramRdata | input | DATA_W | Core read data, COL_LAT cycles after RD |

## Verification
The bench builds the block with BANK_W=1 and TAG_W=2, keeping 128-bit data and eight columns. That gives a 64-word space, so every address can be written and read back exhaustively. With only two banks, bank conflicts and row replacement happen often in sweeps and in a pseudo-random mixed sequence. The bench derives each access's stall count from its own open-row and read-history model. Its behavioural core rejects column commands to closed or mismatched rows, and reports any activate issued to a bank that is already open.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } dramCmd_e;

  typedef struct packed {
    logic accept;
    logic issuePre;
    logic issueAct;
    logic issueRef;
  } ctrlStrobe_t;
endpackage

// File: rtl/rbc_ctrl.sv
module rbc_ctrl
  import rbc_pkg::*;
#(
  parameter int TAG_W    = 9,
  parameter int BANK_W   = 2,
  parameter int MISS_PEN = 10,
  parameter int ROW_PRE  = 3,
  parameter int WAR_PEN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              halt,
  output logic              stall,
  output ctrlStrobe_t       strobe,
  output logic [BANK_W-1:0] actBank,
  output logic [TAG_W-1:0]  actTag
);
  localparam int NBANK   = 1 << BANK_W;
  localparam int PEN_MAX = (MISS_PEN > WAR_PEN) ? MISS_PEN : WAR_PEN;
  localparam int CNT_W   = $clog2(PEN_MAX + 1);
  localparam int ACT_AT  = MISS_PEN - 1 - ROW_PRE;

  logic [NBANK-1:0] openValid;
  logic [TAG_W-1:0] openTag [NBANK];
  logic             lastRead;
  logic [CNT_W-1:0] cnt;
  logic             haltQ, haltQ2;
  logic             inMiss, missPre;
  logic             realign, busy, hitRow, gate, missHz, warHz;

  assign realign = haltQ & ~halt;
  assign busy    = (cnt != '0);
  assign hitRow  = openValid[reqBank] && (openTag[reqBank] == reqTag);
  assign gate    = ~halt & ~realign & ~busy;
  assign missHz  = req & gate & ~hitRow;
  assign warHz   = req & gate & hitRow & we & lastRead;
  assign stall   = halt | realign | busy | missHz | warHz;

  always_comb begin
    strobe          = '0;
    strobe.accept   = req & ~stall;
    strobe.issuePre = inMiss & missPre & (cnt == CNT_W'(MISS_PEN - 1));
    strobe.issueAct = inMiss & (cnt == CNT_W'(ACT_AT));
    strobe.issueRef = haltQ & ~haltQ2;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openValid <= '0;
      for (int i = 0; i < NBANK; i++) openTag[i] <= '0;
      lastRead <= 1'b0;
      cnt      <= '0;
      haltQ    <= 1'b0;
      haltQ2   <= 1'b0;
      inMiss   <= 1'b0;
      missPre  <= 1'b0;
      actBank  <= '0;
      actTag   <= '0;
    end else begin
      haltQ  <= halt;
      haltQ2 <= haltQ;
      if (halt) begin
        cnt    <= '0;
        inMiss <= 1'b0;
        if (!haltQ) begin
          openValid <= '0;
          lastRead  <= 1'b0;
        end
      end else if (missHz) begin
        cnt                <= CNT_W'(MISS_PEN - 1);
        inMiss             <= 1'b1;
        missPre            <= openValid[reqBank];
        actBank            <= reqBank;
        actTag             <= reqTag;
        openValid[reqBank] <= 1'b1;
        openTag[reqBank]   <= reqTag;
        lastRead           <= 1'b0;
      end else if (warHz) begin
        cnt      <= CNT_W'(WAR_PEN - 1);
        inMiss   <= 1'b0;
        lastRead <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) inMiss <= 1'b0;
      end else if (strobe.accept) begin
        lastRead <= ~we;
      end
    end
  end

  // R7: the cycle after a halt ends is always a stall cycle
  p_realign_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halt) |-> stall);

  // R4: the penalty counter steps down by one per cycle outside a halt
  p_countdown_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !halt) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R6: refresh is only issued once every row buffer is closed
  p_ref_rows_closed_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueRef |-> (openValid == '0));
endmodule

// File: rtl/rbc_datapath.sv
module rbc_datapath
  import rbc_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int COL_W   = 3,
  parameter int BANK_W  = 2,
  parameter int TAG_W   = 9,
  parameter int HIT_LAT = 6,
  parameter int COL_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              we,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BANK_W-1:0] actBank,
  input  logic [TAG_W-1:0]  actTag,
  input  logic [DATA_W-1:0] dramRdata,
  output dramCmd_e          dramCmd,
  output logic [BANK_W-1:0] dramBank,
  output logic [TAG_W-1:0]  dramRow,
  output logic [COL_W-1:0]  dramCol,
  output logic [DATA_W-1:0] dramWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int DLY = HIT_LAT - COL_LAT;

  logic [HIT_LAT:0]  vPipe;
  logic [DATA_W-1:0] dPipe [DLY];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramCmd   <= CMD_NOP;
      dramBank  <= '0;
      dramRow   <= '0;
      dramCol   <= '0;
      dramWdata <= '0;
    end else begin
      dramCol   <= reqCol;
      dramWdata <= wdata;
      if (strobe.accept) begin
        dramCmd  <= we ? CMD_WR : CMD_RD;
        dramBank <= reqBank;
        dramRow  <= reqTag;
      end else begin
        dramBank <= actBank;
        dramRow  <= actTag;
        if (strobe.issuePre)      dramCmd <= CMD_PRE;
        else if (strobe.issueAct) dramCmd <= CMD_ACT;
        else if (strobe.issueRef) dramCmd <= CMD_REF;
        else                      dramCmd <= CMD_NOP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) vPipe[0] <= 1'b0;
    else       vPipe[0] <= strobe.accept & ~we;
  end

  always_ff @(posedge clk) dPipe[0] <= dramRdata;

  generate
    for (genvar s = 1; s <= HIT_LAT; s++) begin : g_valid
      always_ff @(posedge clk) begin
        if (!rstN) vPipe[s] <= 1'b0;
        else       vPipe[s] <= vPipe[s-1];
      end
    end
    for (genvar s = 1; s < DLY; s++) begin : g_data
      always_ff @(posedge clk) dPipe[s] <= dPipe[s-1];
    end
  endgenerate

  assign rdValid = vPipe[HIT_LAT];
  assign rdData  = dPipe[DLY-1];

  // R9: control never requests two core commands in one cycle
  p_single_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.accept, strobe.issuePre, strobe.issueAct, strobe.issueRef}));
endmodule

// File: rtl/rowbuf_sram_ctrl.sv
module rowbuf_sram_ctrl
  import rbc_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int COL_W    = 3,
  parameter int BANK_W   = 2,
  parameter int TAG_W    = 9,
  parameter int HIT_LAT  = 6,
  parameter int COL_LAT  = 2,
  parameter int MISS_PEN = 10,
  parameter int ROW_PRE  = 3,
  parameter int WAR_PEN  = 4,
  localparam int ADDR_W  = TAG_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              halt,
  output logic              stall,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [2:0]        dramCmd,
  output logic [BANK_W-1:0] dramBank,
  output logic [TAG_W-1:0]  dramRow,
  output logic [COL_W-1:0]  dramCol,
  output logic [DATA_W-1:0] dramWdata,
  input  logic [DATA_W-1:0] dramRdata
);
  logic [TAG_W-1:0]  reqTag;
  logic [BANK_W-1:0] reqBank;
  logic [COL_W-1:0]  reqCol;
  ctrlStrobe_t       strobe;
  logic [BANK_W-1:0] actBank;
  logic [TAG_W-1:0]  actTag;
  dramCmd_e          cmdQ;

  assign reqCol  = addr[COL_W-1:0];
  assign reqBank = addr[COL_W +: BANK_W];
  assign reqTag  = addr[ADDR_W-1 -: TAG_W];
  assign dramCmd = cmdQ;

  rbc_ctrl #(
    .TAG_W(TAG_W), .BANK_W(BANK_W), .MISS_PEN(MISS_PEN),
    .ROW_PRE(ROW_PRE), .WAR_PEN(WAR_PEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .we(we),
    .reqTag(reqTag), .reqBank(reqBank), .halt(halt),
    .stall(stall), .strobe(strobe), .actBank(actBank), .actTag(actTag)
  );

  rbc_datapath #(
    .DATA_W(DATA_W), .COL_W(COL_W), .BANK_W(BANK_W), .TAG_W(TAG_W),
    .HIT_LAT(HIT_LAT), .COL_LAT(COL_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .we(we),
    .reqTag(reqTag), .reqBank(reqBank), .reqCol(reqCol), .wdata(wdata),
    .actBank(actBank), .actTag(actTag), .dramRdata(dramRdata),
    .dramCmd(cmdQ), .dramBank(dramBank), .dramRow(dramRow),
    .dramCol(dramCol), .dramWdata(dramWdata),
    .rdValid(rdValid), .rdData(rdData)
  );

  // R6: no column command reaches the core once a halt has been held a cycle
  p_no_col_in_halt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (halt && $past(halt)) |-> !(cmdQ == CMD_RD || cmdQ == CMD_WR));
endmodule

// File: tb/tb_rowbuf_sram_ctrl.sv
`timescale 1ns/1ps
module tb_rowbuf_sram_ctrl;
  localparam int DW = 128, CW = 3, BW = 1, TW = 2;
  localparam int AW = TW + BW + CW;
  localparam int NW = 1 << AW;
  localparam int LAT = 6, CLAT = 2, MISS = 10, WAR = 4;

  logic clk = 0, rstN = 0, req = 0, we = 0, halt = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdData, dramWdata, dramRdata;
  logic stall, rdValid;
  logic [2:0] dramCmd;
  logic [BW-1:0] dramBank;
  logic [TW-1:0] dramRow;
  logic [CW-1:0] dramCol;

  rowbuf_sram_ctrl #(.DATA_W(DW), .COL_W(CW), .BANK_W(BW), .TAG_W(TW),
    .HIT_LAT(LAT), .COL_LAT(CLAT), .MISS_PEN(MISS), .WAR_PEN(WAR)) dut (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .halt(halt), .stall(stall), .rdValid(rdValid), .rdData(rdData),
    .dramCmd(dramCmd), .dramBank(dramBank), .dramRow(dramRow),
    .dramCol(dramCol), .dramWdata(dramWdata), .dramRdata(dramRdata));

  always #5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, misses = 0, actCount = 0, refCount = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural core
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] refMem [NW];
  logic [DW-1:0] rdPipe [CLAT];
  logic [1<<BW-1:0] coreOpen;
  logic [TW-1:0] coreRow [1<<BW];
  initial begin
    for (int i = 0; i < NW; i++) begin mem[i] = '0; refMem[i] = '0; end
    coreOpen = '0;
  end
  assign dramRdata = rdPipe[CLAT-1];

  always @(posedge clk) begin
    rdPipe[0] <= '0;
    for (int i = 1; i < CLAT; i++) rdPipe[i] <= rdPipe[i-1];
    if (rstN) begin
      case (dramCmd)
        3'd1: begin
          chk(!coreOpen[dramBank], $sformatf("R9 ACT to open bank %0d act=1 exp=0", dramBank));
          coreOpen[dramBank] <= 1'b1; coreRow[dramBank] <= dramRow; actCount++;
        end
        3'd4: coreOpen[dramBank] <= 1'b0;
        3'd5: begin coreOpen <= '0; refCount++; end
        3'd2, 3'd3: begin
          chk(coreOpen[dramBank] && coreRow[dramBank] == dramRow,
              $sformatf("R9 column cmd row act=%0d exp=%0d open=%0d",
                        dramRow, coreRow[dramBank], coreOpen[dramBank]));
          if (dramCmd == 3'd2) rdPipe[0] <= mem[{dramRow, dramBank, dramCol}];
          else mem[{dramRow, dramBank, dramCol}] <= dramWdata;
        end
        default: ;
      endcase
    end
  end

  // read return monitor
  logic [DW-1:0] expQ [256];
  int expCyc [256];
  int qHead = 0, qTail = 0;
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (qHead == qTail) chk(0, "R3 unexpected rdValid act=1 exp=0");
      else begin
        chk(rdData == expQ[qHead[7:0]], $sformatf("R8 read data act=%h exp=%h", rdData, expQ[qHead[7:0]]));
        chk(cyc - expCyc[qHead[7:0]] == LAT, $sformatf("R3 latency act=%0d exp=%0d", cyc - expCyc[qHead[7:0]], LAT));
        qHead++;
      end
    end
  end

  // bench row model
  bit bV [2];
  int bT [2];
  bit bLastRd = 0;

  function automatic logic [DW-1:0] pat(input int a, input int s);
    logic [31:0] w = 32'(a) * 32'h9E3779B1 + 32'(s);
    return {w, ~w, w ^ 32'h5A5A5A5A, 32'(a)};
  endfunction

  task automatic access(input bit w, input int a, input logic [DW-1:0] d);
    int n, e, b, t;
    b = (a >> CW) & 1; t = a >> (CW + BW);
    e = (!bV[b] || bT[b] != t) ? MISS : (w && bLastRd) ? WAR : 0;
    @(negedge clk); req = 1; we = w; addr = AW'(a); wdata = d; #1;
    n = 0;
    while (stall === 1'b1 && n < 100) begin @(negedge clk); #1; n++; end
    if (e == MISS) chk(n == e, $sformatf("R4 miss stall a=%0d act=%0d exp=%0d", a, n, e));
    else if (e == WAR) chk(n == e, $sformatf("R5 write-after-read stall a=%0d act=%0d exp=%0d", a, n, e));
    else chk(n == e, $sformatf("R2 hit stall a=%0d act=%0d exp=%0d", a, n, e));
    if (e == MISS) begin bV[b] = 1; bT[b] = t; misses++; end
    bLastRd = !w;
    if (w) refMem[a] = d;
    else begin expQ[qTail[7:0]] = refMem[a]; expCyc[qTail[7:0]] = cyc + 1; qTail++; end
  endtask

  task automatic idle(input int n);
    @(negedge clk); req = 0; we = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic doHalt(input int len);
    int r0;
    r0 = refCount;
    @(negedge clk); req = 0; halt = 1;
    for (int i = 0; i < len; i++) begin
      #1 chk(stall === 1'b1, $sformatf("R6 stall in halt act=%b exp=1", stall));
      @(negedge clk);
    end
    halt = 0; #1;
    chk(stall === 1'b1, $sformatf("R7 realign stall act=%b exp=1", stall));
    @(negedge clk); #1;
    chk(stall === 1'b0, $sformatf("R7 stall after realign act=%b exp=0", stall));
    repeat (3) @(negedge clk);
    chk(refCount == r0 + 1, $sformatf("R6 REF count act=%0d exp=%0d", refCount - r0, 1));
    bV[0] = 0; bV[1] = 0; bLastRd = 0;
  endtask

  initial begin
    int x;
    bV[0] = 0; bV[1] = 0; bT[0] = 0; bT[1] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(stall === 1'b0, $sformatf("R1 stall act=%b exp=0", stall));
    chk(rdValid === 1'b0, $sformatf("R1 rdValid act=%b exp=0", rdValid));
    chk(dramCmd === 3'd0, $sformatf("R1 dramCmd act=%0d exp=0", dramCmd));
    // R8 exhaustive write then read sweep
    for (int a = 0; a < NW; a++) access(1, a, pat(a, 1));
    for (int a = 0; a < NW; a++) access(0, a, '0);
    idle(10);
    // R3 back-to-back hits within one row
    for (int c = 0; c < 8; c++) access(0, 8 + c, '0);
    // R5 write after read on a hit row, then write that misses
    access(1, 9, pat(9, 2));
    access(0, 9, '0);
    access(1, 9 + 32, pat(41, 2));
    access(0, 10, '0);
    access(1, 10, pat(10, 3));
    idle(10);
    // R6/R7 halts of several lengths, each followed by misses
    doHalt(5);
    access(0, 9, '0);
    access(1, 9, pat(9, 4));
    doHalt(1);
    access(1, 3, pat(3, 5));
    access(0, 3, '0);
    idle(10);
    // mixed pseudo-random traffic
    x = 7;
    for (int k = 0; k < 300; k++) begin
      x = x * 1103515245 + 12345;
      access(((x >> 20) & 1) == 1, (x >> 8) & (NW - 1), pat(k, 9));
      if (k % 97 == 96) doHalt(2 + k % 3);
    end
    idle(15);
    chk(qHead == qTail, $sformatf("R3 reads outstanding act=%0d exp=0", qTail - qHead));
    chk(actCount == misses, $sformatf("R4 ACT count act=%0d exp=%0d", actCount, misses));
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule